// File: doc/BRIEF.md
# AXI Transaction ID and Sideband Remapper

This block sits on the read and write address channels between an interconnect and a coherency port. On every accepted request it rewrites three fields: the 12-bit incoming transaction ID becomes a 3-bit output ID, the 5-bit user sideband is replaced (bit 0 marks a shared access, bits 4:1 carry inner cache attributes), and the top two address bits are overwritten by a 2-bit page number, so the downstream port sees a 1 GB window. On the response channels the 3-bit ID is translated back to the original 12-bit ID before the response goes upstream.

Each channel has its own configuration: a mode bit, a default user value, a default page, an ID compare mask and a table of eight entries. In dynamic mode every request takes the default user and page, and each distinct in-flight input ID gets its own output ID from a free pool. In fixed mode an input ID that matches a table entry under the mask is sent on that entry's index with that entry's user and page. Requests from the bridge source keep their own user bits in both modes. Configuration is loaded through a simple write port.

Top module: `axi_id_remap`

## Requirements
- R1: After reset both channels are in dynamic mode with default user 0, default page 0, all output IDs free and no output valid; the first write request with ID 0x123 leaves on output ID 0 with user 0 and address bits 31:30 equal to 0.
- R2: In dynamic mode a request's user is the channel default, address bits 31:30 are the default page, bits 29:0 pass unchanged, and a new input ID takes the lowest-numbered free output ID.
- R3: A request whose input ID already owns an output ID reuses that output ID.
- R4: When no usable output ID exists (all in the pool busy, the matched one held by a different input ID, or its outstanding count at MAX_OUT) the upstream ready and downstream valid are both low.
- R5: A response carries the original 12-bit ID upstream; a write response frees one outstanding request, a read response frees one only when its last flag is set, and an output ID returns to the pool when its count reaches zero.
- R6: In fixed mode an input ID equal to a valid entry's ID on every bit set in the mask uses that entry's index as output ID and that entry's user and page; the lowest matching index wins.
- R7: In fixed mode an unmatched request is allocated as in dynamic mode from output IDs whose entry is not valid, with the default user and page.
- R8: A request whose ID satisfies (id & 12'h807) == 12'h000 keeps its own user bits in both modes; page and output ID are still remapped.
- R9: Write-channel configuration has no effect on the read channel and vice versa.
- R10: A configuration write applies to requests accepted in later cycles, including on an output ID already in flight.
- R11: Configuration map: cfg_addr[4] selects the channel (0 write, 1 read); cfg_addr[3:0] 0..7 is an entry word (bit 31 valid, bits 18:17 page, 16:12 user, 11:0 ID), 8 is the control word (bit 31 fixed mode, bits 6:5 page, 4:0 user), 9 is the mask word (bits 11:0, reset 12'hFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| s_awvalid | input | 1 | Upstream write address valid |
| s_awready | output | 1 | Upstream write address ready |
| s_awid | input | 12 | Upstream write ID |
| s_awaddr | input | 32 | Upstream write address |
| s_awuser | input | 5 | Upstream write user sideband |
| m_awvalid | output | 1 | Downstream write address valid |
| m_awready | input | 1 | Downstream write address ready |
| m_awid | output | 3 | Downstream write ID |
| m_awaddr | output | 32 | Downstream write address |
| m_awuser | output | 5 | Downstream write user sideband |
| s_arvalid | input | 1 | Upstream read address valid |
| s_arready | output | 1 | Upstream read address ready |
| s_arid | input | 12 | Upstream read ID |
| s_araddr | input | 32 | Upstream read address |
| s_aruser | input | 5 | Upstream read user sideband |
| m_arvalid | output | 1 | Downstream read address valid |
| m_arready | input | 1 | Downstream read address ready |
| m_arid | output | 3 | Downstream read ID |
| m_araddr | output | 32 | Downstream read address |
| m_aruser | output | 5 | Downstream read user sideband |
| m_bvalid | input | 1 | Downstream write response valid |
| m_bready | output | 1 | Downstream write response ready |
| m_bid | input | 3 | Downstream write response ID |
| m_bresp | input | 2 | Downstream write response code |
| s_bvalid | output | 1 | Upstream write response valid |
| s_bready | input | 1 | Upstream write response ready |
| s_bid | output | 12 | Restored write response ID |
| s_bresp | output | 2 | Upstream write response code |
| m_rvalid | input | 1 | Downstream read data valid |
| m_rready | output | 1 | Downstream read data ready |
| m_rid | input | 3 | Downstream read ID |
| m_rdata | input | 32 | Downstream read data |
| m_rresp | input | 2 | Downstream read response code |
| m_rlast | input | 1 | Downstream read last beat |
| s_rvalid | output | 1 | Upstream read data valid |
| s_rready | input | 1 | Upstream read data ready |
| s_rid | output | 12 | Restored read ID |
| s_rdata | output | 32 | Upstream read data |
| s_rresp | output | 2 | Upstream read response code |
| s_rlast | output | 1 | Upstream read last beat |

## Verification
The bench builds the block at its defaults: eight output IDs, up to four outstanding requests per output ID, and the bypass pattern 12'h807/12'h000. Eight output IDs are few enough that a short sequence of distinct write IDs exhausts the pool, which brings the stall, the release by a write response, the two-step release of an ID with two requests outstanding, and lowest-free allocation after a release within reach. On the read channel the fixed table with a mask of 12'hFF0 lets variable low ID bits, an unmatched ID falling back to the pool, a bypass ID inside a table entry, and a mid-flight entry rewrite all be driven in a few dozen cycles.

// File: rtl/axrm_pkg.sv
package axrm_pkg;
  localparam int ID_IN_W = 12;
  localparam int USER_W  = 5;
  localparam int PAGE_W  = 2;
  localparam int ADDR_W  = 32;
  localparam int CFG_AW  = 5;
  localparam int CFG_DW  = 32;

  typedef struct packed {
    logic               vld;
    logic [ID_IN_W-1:0] id;
    logic [USER_W-1:0]  user;
    logic [PAGE_W-1:0]  page;
  } tbl_ent_t;
endpackage

// File: rtl/axrm_rst_sync.sv
module axrm_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/axrm_cfg_bank.sv
module axrm_cfg_bank
  import axrm_pkg::*;
#(
  parameter int   NUM_OUT = 8,
  parameter logic CH_SEL  = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [CFG_AW-1:0]           cfg_addr,
  input  logic [CFG_DW-1:0]           cfg_wdata,
  output tbl_ent_t [NUM_OUT-1:0]      ent_o,
  output logic [USER_W-1:0]           dflt_user_o,
  output logic [PAGE_W-1:0]           dflt_page_o,
  output logic [ID_IN_W-1:0]          mask_o,
  output logic                        fixed_o
);
  localparam logic [3:0] CTRL_WORD = 4'd8;
  localparam logic [3:0] MASK_WORD = 4'd9;

  tbl_ent_t [NUM_OUT-1:0] ent_q, ent_d;
  logic [USER_W-1:0]      user_q, user_d;
  logic [PAGE_W-1:0]      page_q, page_d;
  logic [ID_IN_W-1:0]     mask_q, mask_d;
  logic                   fixed_q, fixed_d;
  logic                   sel_ch;
  logic [3:0]             word;
  tbl_ent_t               wr_ent;

  assign sel_ch = cfg_we && (cfg_addr[4] == CH_SEL);
  assign word   = cfg_addr[3:0];

  always_comb begin
    wr_ent.vld  = cfg_wdata[31];
    wr_ent.page = cfg_wdata[18:17];
    wr_ent.user = cfg_wdata[16:12];
    wr_ent.id   = cfg_wdata[11:0];
  end

  always_comb begin
    ent_d   = ent_q;
    user_d  = user_q;
    page_d  = page_q;
    mask_d  = mask_q;
    fixed_d = fixed_q;
    if (sel_ch) begin
      for (int i = 0; i < NUM_OUT; i++) begin
        if (word == 4'(i)) ent_d[i] = wr_ent;
      end
      if (word == CTRL_WORD) begin
        fixed_d = cfg_wdata[31];
        page_d  = cfg_wdata[6:5];
        user_d  = cfg_wdata[4:0];
      end
      if (word == MASK_WORD) mask_d = cfg_wdata[ID_IN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q   <= '0;
      user_q  <= '0;
      page_q  <= '0;
      mask_q  <= '1;
      fixed_q <= 1'b0;
    end else if (sel_ch) begin
      ent_q   <= ent_d;
      user_q  <= user_d;
      page_q  <= page_d;
      mask_q  <= mask_d;
      fixed_q <= fixed_d;
    end
  end

  assign ent_o       = ent_q;
  assign dflt_user_o = user_q;
  assign dflt_page_o = page_q;
  assign mask_o      = mask_q;
  assign fixed_o     = fixed_q;
endmodule

// File: rtl/axrm_slot_track.sv
module axrm_slot_track
  import axrm_pkg::*;
#(
  parameter int NUM_OUT = 8,
  parameter int MAX_OUT = 4,
  localparam int OID_W  = $clog2(NUM_OUT),
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             acc_i,
  input  logic [OID_W-1:0]                 acc_slot_i,
  input  logic [ID_IN_W-1:0]               acc_id_i,
  input  logic                             rel_i,
  input  logic [OID_W-1:0]                 rel_slot_i,
  output logic [NUM_OUT-1:0]               busy_o,
  output logic [NUM_OUT-1:0]               full_o,
  output logic [NUM_OUT-1:0][ID_IN_W-1:0]  orig_o
);
  logic [NUM_OUT-1:0][CNT_W-1:0]   cnt_q, cnt_d;
  logic [NUM_OUT-1:0][ID_IN_W-1:0] id_q, id_d;
  logic [NUM_OUT-1:0]              upd;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_slot
    logic inc, dec;
    assign inc = acc_i && (acc_slot_i == OID_W'(g));
    assign dec = rel_i && (rel_slot_i == OID_W'(g)) && (cnt_q[g] != '0);
    assign upd[g] = inc || dec;

    always_comb begin
      cnt_d[g] = cnt_q[g];
      id_d[g]  = id_q[g];
      if (inc && !dec) cnt_d[g] = cnt_q[g] + CNT_W'(1);
      if (dec && !inc) cnt_d[g] = cnt_q[g] - CNT_W'(1);
      if (inc && (cnt_q[g] == '0)) id_d[g] = acc_id_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[g] <= '0;
        id_q[g]  <= '0;
      end else if (upd[g]) begin
        cnt_q[g] <= cnt_d[g];
        id_q[g]  <= id_d[g];
      end
    end

    assign busy_o[g] = (cnt_q[g] != '0);
    assign full_o[g] = (cnt_q[g] == CNT_W'(MAX_OUT));
  end

  assign orig_o = id_q;
endmodule

// File: rtl/axrm_addr_map.sv
module axrm_addr_map
  import axrm_pkg::*;
#(
  parameter int                 NUM_OUT   = 8,
  parameter logic [ID_IN_W-1:0] BYP_MASK  = 12'h807,
  parameter logic [ID_IN_W-1:0] BYP_MATCH = 12'h000,
  localparam int                OID_W     = $clog2(NUM_OUT)
) (
  input  logic                             s_valid_i,
  output logic                             s_ready_o,
  input  logic [ID_IN_W-1:0]               s_id_i,
  input  logic [ADDR_W-1:0]                s_addr_i,
  input  logic [USER_W-1:0]                s_user_i,
  output logic                             m_valid_o,
  input  logic                             m_ready_i,
  output logic [OID_W-1:0]                 m_id_o,
  output logic [ADDR_W-1:0]                m_addr_o,
  output logic [USER_W-1:0]                m_user_o,
  input  tbl_ent_t [NUM_OUT-1:0]           ent_i,
  input  logic [USER_W-1:0]                dflt_user_i,
  input  logic [PAGE_W-1:0]                dflt_page_i,
  input  logic [ID_IN_W-1:0]               mask_i,
  input  logic                             fixed_i,
  input  logic [NUM_OUT-1:0]               busy_i,
  input  logic [NUM_OUT-1:0]               full_i,
  input  logic [NUM_OUT-1:0][ID_IN_W-1:0]  orig_i,
  output logic                             acc_o,
  output logic [OID_W-1:0]                 acc_slot_o
);
  localparam int LOW_W = ADDR_W - PAGE_W;

  logic [NUM_OUT-1:0] pool;
  logic               fix_hit, reuse_hit, free_hit, ok, bypass;
  logic [OID_W-1:0]   fix_idx, reuse_idx, free_idx, slot;
  logic [USER_W-1:0]  user_sel;
  logic [PAGE_W-1:0]  page_sel;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_pool
    assign pool[g] = !(fixed_i && ent_i[g].vld);
  end

  always_comb begin
    fix_hit   = 1'b0;
    fix_idx   = '0;
    reuse_hit = 1'b0;
    reuse_idx = '0;
    free_hit  = 1'b0;
    free_idx  = '0;
    for (int i = NUM_OUT - 1; i >= 0; i--) begin
      if (fixed_i && ent_i[i].vld && (((s_id_i ^ ent_i[i].id) & mask_i) == '0)) begin
        fix_hit = 1'b1;
        fix_idx = OID_W'(i);
      end
      if (pool[i] && busy_i[i] && (orig_i[i] == s_id_i)) begin
        reuse_hit = 1'b1;
        reuse_idx = OID_W'(i);
      end
      if (pool[i] && !busy_i[i]) begin
        free_hit = 1'b1;
        free_idx = OID_W'(i);
      end
    end
  end

  always_comb begin
    slot     = '0;
    ok       = 1'b0;
    user_sel = dflt_user_i;
    page_sel = dflt_page_i;
    if (fix_hit) begin
      slot     = fix_idx;
      ok       = !full_i[fix_idx] && (!busy_i[fix_idx] || (orig_i[fix_idx] == s_id_i));
      user_sel = ent_i[fix_idx].user;
      page_sel = ent_i[fix_idx].page;
    end else if (reuse_hit) begin
      slot = reuse_idx;
      ok   = !full_i[reuse_idx];
    end else if (free_hit) begin
      slot = free_idx;
      ok   = 1'b1;
    end
  end

  assign bypass     = ((s_id_i & BYP_MASK) == BYP_MATCH);
  assign m_user_o   = bypass ? s_user_i : user_sel;
  assign m_addr_o   = {page_sel, s_addr_i[LOW_W-1:0]};
  assign m_id_o     = slot;
  assign m_valid_o  = s_valid_i && ok;
  assign s_ready_o  = m_ready_i && ok;
  assign acc_o      = s_valid_i && ok && m_ready_i;
  assign acc_slot_o = slot;
endmodule

// File: rtl/axi_id_remap.sv
module axi_id_remap
  import axrm_pkg::*;
#(
  parameter int                 NUM_OUT   = 8,
  parameter int                 MAX_OUT   = 4,
  parameter int                 DATA_W    = 32,
  parameter logic [ID_IN_W-1:0] BYP_MASK  = 12'h807,
  parameter logic [ID_IN_W-1:0] BYP_MATCH = 12'h000,
  localparam int                OID_W     = $clog2(NUM_OUT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [CFG_DW-1:0]   cfg_wdata,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [ID_IN_W-1:0]  s_awid,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic [USER_W-1:0]   s_awuser,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [OID_W-1:0]    m_awid,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [USER_W-1:0]   m_awuser,
  input  logic                s_arvalid,
  output logic                s_arready,
  input  logic [ID_IN_W-1:0]  s_arid,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic [USER_W-1:0]   s_aruser,
  output logic                m_arvalid,
  input  logic                m_arready,
  output logic [OID_W-1:0]    m_arid,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [USER_W-1:0]   m_aruser,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [OID_W-1:0]    m_bid,
  input  logic [1:0]          m_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [ID_IN_W-1:0]  s_bid,
  output logic [1:0]          s_bresp,
  input  logic                m_rvalid,
  output logic                m_rready,
  input  logic [OID_W-1:0]    m_rid,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rlast,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [ID_IN_W-1:0]  s_rid,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rlast
);
  localparam int NUM_CH = 2;

  logic                                          rst_n_s;
  logic [NUM_CH-1:0]                             ch_svalid, ch_sready, ch_mvalid, ch_mready;
  logic [NUM_CH-1:0]                             ch_acc, ch_rel;
  logic [NUM_CH-1:0][ID_IN_W-1:0]                ch_sid;
  logic [NUM_CH-1:0][ADDR_W-1:0]                 ch_saddr, ch_maddr;
  logic [NUM_CH-1:0][USER_W-1:0]                 ch_suser, ch_muser;
  logic [NUM_CH-1:0][OID_W-1:0]                  ch_mid, ch_accslot, ch_relslot;
  logic [NUM_CH-1:0][NUM_OUT-1:0][ID_IN_W-1:0]   ch_orig;

  axrm_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s));

  assign ch_svalid  = {s_arvalid, s_awvalid};
  assign ch_sid     = {s_arid, s_awid};
  assign ch_saddr   = {s_araddr, s_awaddr};
  assign ch_suser   = {s_aruser, s_awuser};
  assign ch_mready  = {m_arready, m_awready};
  assign ch_rel     = {m_rvalid && s_rready && m_rlast, m_bvalid && s_bready};
  assign ch_relslot = {m_rid, m_bid};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tbl_ent_t [NUM_OUT-1:0] ent;
    logic [USER_W-1:0]      dflt_user;
    logic [PAGE_W-1:0]      dflt_page;
    logic [ID_IN_W-1:0]     mask;
    logic                   fixed;
    logic [NUM_OUT-1:0]     busy, full;

    axrm_cfg_bank #(.NUM_OUT(NUM_OUT), .CH_SEL(c[0])) u_cfg (
      .clk(clk), .rst_n(rst_n_s), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .ent_o(ent), .dflt_user_o(dflt_user),
      .dflt_page_o(dflt_page), .mask_o(mask), .fixed_o(fixed)
    );

    axrm_slot_track #(.NUM_OUT(NUM_OUT), .MAX_OUT(MAX_OUT)) u_trk (
      .clk(clk), .rst_n(rst_n_s), .acc_i(ch_acc[c]), .acc_slot_i(ch_accslot[c]),
      .acc_id_i(ch_sid[c]), .rel_i(ch_rel[c]), .rel_slot_i(ch_relslot[c]),
      .busy_o(busy), .full_o(full), .orig_o(ch_orig[c])
    );

    axrm_addr_map #(.NUM_OUT(NUM_OUT), .BYP_MASK(BYP_MASK), .BYP_MATCH(BYP_MATCH)) u_map (
      .s_valid_i(ch_svalid[c]), .s_ready_o(ch_sready[c]), .s_id_i(ch_sid[c]),
      .s_addr_i(ch_saddr[c]), .s_user_i(ch_suser[c]), .m_valid_o(ch_mvalid[c]),
      .m_ready_i(ch_mready[c]), .m_id_o(ch_mid[c]), .m_addr_o(ch_maddr[c]),
      .m_user_o(ch_muser[c]), .ent_i(ent), .dflt_user_i(dflt_user),
      .dflt_page_i(dflt_page), .mask_i(mask), .fixed_i(fixed), .busy_i(busy),
      .full_i(full), .orig_i(ch_orig[c]), .acc_o(ch_acc[c]), .acc_slot_o(ch_accslot[c])
    );
  end

  assign s_awready = ch_sready[0];
  assign m_awvalid = ch_mvalid[0];
  assign m_awid    = ch_mid[0];
  assign m_awaddr  = ch_maddr[0];
  assign m_awuser  = ch_muser[0];
  assign s_arready = ch_sready[1];
  assign m_arvalid = ch_mvalid[1];
  assign m_arid    = ch_mid[1];
  assign m_araddr  = ch_maddr[1];
  assign m_aruser  = ch_muser[1];

  assign s_bvalid = m_bvalid;
  assign m_bready = s_bready;
  assign s_bresp  = m_bresp;
  assign s_bid    = ch_orig[0][m_bid];

  assign s_rvalid = m_rvalid;
  assign m_rready = s_rready;
  assign s_rdata  = m_rdata;
  assign s_rresp  = m_rresp;
  assign s_rlast  = m_rlast;
  assign s_rid    = ch_orig[1][m_rid];
endmodule

// File: rtl/axi_id_remap_chk.sv
module axi_id_remap_chk #(
  parameter int OID_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_awvalid,
  input logic             s_awready,
  input logic             m_awvalid,
  input logic             m_awready,
  input logic             s_arvalid,
  input logic             s_arready,
  input logic             m_arvalid,
  input logic             m_arready,
  input logic             m_bvalid,
  input logic [OID_W-1:0] m_bid,
  input logic             s_bvalid,
  input logic             s_bready,
  input logic [11:0]      s_bid,
  input logic             m_rvalid,
  input logic [OID_W-1:0] m_rid,
  input logic             s_rvalid,
  input logic             s_rready,
  input logic [11:0]      s_rid
);
  // R4: downstream valid only while an upstream request is present
  p_awvalid_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> s_awvalid);
  p_arvalid_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> s_arvalid);
  // R4: upstream ready never raised while downstream is not ready
  p_awready_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_awready |-> m_awready);
  p_arready_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_arready |-> m_arready);
  // R5: a stalled response with a held output ID keeps its restored ID
  p_bid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) ##1 (m_bvalid && $stable(m_bid)) |-> $stable(s_bid));
  p_rid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) ##1 (m_rvalid && $stable(m_rid)) |-> $stable(s_rid));
endmodule

bind axi_id_remap axi_id_remap_chk #(.OID_W(OID_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_awvalid(s_awvalid), .s_awready(s_awready), .m_awvalid(m_awvalid), .m_awready(m_awready),
  .s_arvalid(s_arvalid), .s_arready(s_arready), .m_arvalid(m_arvalid), .m_arready(m_arready),
  .m_bvalid(m_bvalid), .m_bid(m_bid), .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid),
  .m_rvalid(m_rvalid), .m_rid(m_rid), .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rid(s_rid)
);

// File: tb/axi_id_remap_tb_top.sv
module axi_id_remap_tb_top;
  logic        clk, rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        s_awvalid, s_awready, m_awvalid, m_awready;
  logic [11:0] s_awid;
  logic [31:0] s_awaddr, m_awaddr;
  logic [4:0]  s_awuser, m_awuser;
  logic [2:0]  m_awid;
  logic        s_arvalid, s_arready, m_arvalid, m_arready;
  logic [11:0] s_arid;
  logic [31:0] s_araddr, m_araddr;
  logic [4:0]  s_aruser, m_aruser;
  logic [2:0]  m_arid;
  logic        m_bvalid, m_bready, s_bvalid, s_bready;
  logic [2:0]  m_bid;
  logic [1:0]  m_bresp, s_bresp;
  logic [11:0] s_bid;
  logic        m_rvalid, m_rready, s_rvalid, s_rready, m_rlast, s_rlast;
  logic [2:0]  m_rid;
  logic [31:0] m_rdata, s_rdata;
  logic [1:0]  m_rresp, s_rresp;
  logic [11:0] s_rid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    string       req;
    logic [2:0]  oid;
    logic [31:0] addr;
    logic [4:0]  user;
  } exp_t;
  exp_t aw_q[$];
  exp_t ar_q[$];
  exp_t e_aw, e_ar;

  axi_id_remap dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // scoreboard monitors: compare each downstream handshake with the queue head
  always begin
    @(negedge clk); #2;
    if (rst_n && m_awvalid && m_awready) begin
      if (aw_q.size() == 0) chk("R2", "unexpected aw", 32'(m_awid), 32'hFFFF_FFFF);
      else begin
        e_aw = aw_q.pop_front();
        chk(e_aw.req, "awid", 32'(m_awid), 32'(e_aw.oid));
        chk(e_aw.req, "awaddr", m_awaddr, e_aw.addr);
        chk(e_aw.req, "awuser", 32'(m_awuser), 32'(e_aw.user));
      end
    end
    if (rst_n && m_arvalid && m_arready) begin
      if (ar_q.size() == 0) chk("R2", "unexpected ar", 32'(m_arid), 32'hFFFF_FFFF);
      else begin
        e_ar = ar_q.pop_front();
        chk(e_ar.req, "arid", 32'(m_arid), 32'(e_ar.oid));
        chk(e_ar.req, "araddr", m_araddr, e_ar.addr);
        chk(e_ar.req, "aruser", 32'(m_aruser), 32'(e_ar.user));
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    s_awvalid = 0; s_awid = '0; s_awaddr = '0; s_awuser = '0; m_awready = 1;
    s_arvalid = 0; s_arid = '0; s_araddr = '0; s_aruser = '0; m_arready = 1;
    m_bvalid = 0; m_bid = '0; m_bresp = '0; s_bready = 1;
    m_rvalid = 0; m_rid = '0; m_rdata = '0; m_rresp = '0; m_rlast = 0; s_rready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic aw_send(input string req, input logic [11:0] id, input logic [31:0] addr,
                         input logic [4:0] user, input logic [2:0] eo, input logic [31:0] ea,
                         input logic [4:0] eu);
    int n;
    exp_t e;
    e.req = req; e.oid = eo; e.addr = ea; e.user = eu;
    aw_q.push_back(e);
    @(negedge clk);
    s_awvalid = 1; s_awid = id; s_awaddr = addr; s_awuser = user;
    #1;
    n = 0;
    while (!s_awready && n < 40) begin @(negedge clk); #1; n++; end
    if (n >= 40) chk(req, "aw accept timeout", 32'(s_awready), 32'd1);
    @(negedge clk);
    s_awvalid = 0;
  endtask

  task automatic ar_send(input string req, input logic [11:0] id, input logic [31:0] addr,
                         input logic [4:0] user, input logic [2:0] eo, input logic [31:0] ea,
                         input logic [4:0] eu);
    int n;
    exp_t e;
    e.req = req; e.oid = eo; e.addr = ea; e.user = eu;
    ar_q.push_back(e);
    @(negedge clk);
    s_arvalid = 1; s_arid = id; s_araddr = addr; s_aruser = user;
    #1;
    n = 0;
    while (!s_arready && n < 40) begin @(negedge clk); #1; n++; end
    if (n >= 40) chk(req, "ar accept timeout", 32'(s_arready), 32'd1);
    @(negedge clk);
    s_arvalid = 0;
  endtask

  task automatic aw_stall(input string req, input logic [11:0] id);
    @(negedge clk);
    s_awvalid = 1; s_awid = id; s_awaddr = '0; s_awuser = '0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(req, "awready low", 32'(s_awready), 32'd0);
      chk(req, "m_awvalid low", 32'(m_awvalid), 32'd0);
      @(negedge clk);
    end
    s_awvalid = 0;
  endtask

  task automatic ar_stall(input string req, input logic [11:0] id);
    @(negedge clk);
    s_arvalid = 1; s_arid = id; s_araddr = '0; s_aruser = '0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(req, "arready low", 32'(s_arready), 32'd0);
      chk(req, "m_arvalid low", 32'(m_arvalid), 32'd0);
      @(negedge clk);
    end
    s_arvalid = 0;
  endtask

  task automatic b_resp(input string req, input logic [2:0] oid, input logic [11:0] exp_id);
    @(negedge clk);
    m_bvalid = 1; m_bid = oid; m_bresp = 2'b00;
    #2;
    chk(req, "bvalid", 32'(s_bvalid), 32'd1);
    chk(req, "bid", 32'(s_bid), 32'(exp_id));
    @(negedge clk);
    m_bvalid = 0;
  endtask

  task automatic r_resp(input string req, input logic [2:0] oid, input logic last, input logic [11:0] exp_id);
    @(negedge clk);
    m_rvalid = 1; m_rid = oid; m_rlast = last; m_rdata = 32'hA5A5_0000 | 32'(oid);
    #2;
    chk(req, "rid", 32'(s_rid), 32'(exp_id));
    chk(req, "rlast", 32'(s_rlast), 32'(last));
    @(negedge clk);
    m_rvalid = 0; m_rlast = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // R1: idle outputs and reset defaults
    chk("R1", "m_awvalid idle", 32'(m_awvalid), 32'd0);
    chk("R1", "m_arvalid idle", 32'(m_arvalid), 32'd0);
    aw_send("R1", 12'h123, 32'hC000_0010, 5'h0A, 3'd0, 32'h0000_0010, 5'h00);

    // R11 control word write channel: user 1F, page 2
    cfg_wr(5'h08, 32'h0000_005F);
    // R2/R10: new ID takes lowest free output ID and new defaults
    aw_send("R2", 12'h456, 32'h1234_5678, 5'h00, 3'd1, 32'h9234_5678, 5'h1F);
    // R3: ID 0x123 still owns output ID 0
    aw_send("R3", 12'h123, 32'h0000_0020, 5'h00, 3'd0, 32'h8000_0020, 5'h1F);
    // R9: read channel keeps its reset defaults
    ar_send("R9", 12'h456, 32'h4000_0004, 5'h07, 3'd0, 32'h0000_0004, 5'h00);
    // R8: bypass pattern keeps own user
    aw_send("R8", 12'h010, 32'h0000_0000, 5'h0A, 3'd2, 32'h8000_0000, 5'h0A);
    for (int k = 1; k <= 5; k++)
      aw_send("R2", 12'h300 + 12'(k), 32'h0000_0000, 5'h00, 3'(k + 2), 32'h8000_0000, 5'h1F);
    // R4: pool exhausted
    aw_stall("R4", 12'h3FF);
    // R5: release output ID 1 restores 0x456, then it is reused
    b_resp("R5", 3'd1, 12'h456);
    aw_send("R5", 12'h3FF, 32'h0000_0100, 5'h00, 3'd1, 32'h8000_0100, 5'h1F);
    b_resp("R5", 3'd0, 12'h123);
    aw_stall("R5", 12'h555);
    b_resp("R5", 3'd0, 12'h123);
    aw_send("R5", 12'h555, 32'h0000_0000, 5'h00, 3'd0, 32'h8000_0000, 5'h1F);
    // R5: read frees only on last beat
    r_resp("R5", 3'd0, 1'b0, 12'h456);
    ar_send("R5", 12'h789, 32'h0000_0000, 5'h00, 3'd1, 32'h0000_0000, 5'h00);
    r_resp("R5", 3'd0, 1'b1, 12'h456);
    ar_send("R5", 12'h78A, 32'h0000_0000, 5'h00, 3'd0, 32'h0000_0000, 5'h00);

    // Fixed mode on the read channel
    do_reset();
    cfg_wr(5'h19, 32'h0000_0FF0);
    cfg_wr(5'h15, 32'h8007_F840);
    cfg_wr(5'h16, 32'h8002_4000);
    cfg_wr(5'h18, 32'h8000_0003);
    // R6: masked match on entry 5
    ar_send("R6", 12'h84A, 32'h0000_1000, 5'h00, 3'd5, 32'hC000_1000, 5'h1F);
    // R4: matched output ID held by a different input ID
    ar_stall("R4", 12'h84B);
    // R10: entry rewrite applies to the next request on the busy ID
    cfg_wr(5'h15, 32'h8007_1840);
    ar_send("R10", 12'h84A, 32'h0000_0010, 5'h00, 3'd5, 32'hC000_0010, 5'h11);
    // R7: unmatched falls back to pool with defaults
    ar_send("R7", 12'h101, 32'h4000_0000, 5'h1E, 3'd0, 32'h0000_0000, 5'h03);
    // R8: bypass inside a fixed entry
    ar_send("R8", 12'h008, 32'h0000_0000, 5'h0C, 3'd6, 32'h4000_0000, 5'h0C);
    r_resp("R5", 3'd5, 1'b1, 12'h84A);
    r_resp("R5", 3'd5, 1'b1, 12'h84A);
    ar_send("R6", 12'h84B, 32'h0000_0000, 5'h00, 3'd5, 32'hC000_0000, 5'h11);
    // R9: write channel stays dynamic with reset defaults
    aw_send("R9", 12'h84A, 32'hC000_0008, 5'h00, 3'd0, 32'h0000_0008, 5'h00);

    repeat (4) @(negedge clk);
    chk("R2", "aw queue drained", 32'(aw_q.size()), 32'd0);
    chk("R6", "ar queue drained", 32'(ar_q.size()), 32'd0);
    finish_run();
  end
endmodule